// File: doc/BRIEF.md
# Addition-Only Scalar-Vector Product Engine

This block multiplies one unsigned scalar by every element of a small unsigned vector. It has no multiplier array. The vector and scalar are loaded in parallel when `start` is accepted. The engine then runs a preprocessing sequence:

- It strips the trailing zero bits from each element and records the shift count.
- It sorts the odd residues that remain.
- It merges equal residues and keeps each distinct residue as its step up from the previous one.

Each step is then scaled by the scalar in one shared shift-and-add unit. That unit stops as soon as the step's remaining bits are zero, so small steps cost few cycles. A running sum rebuilds the scaled distinct residues. Each element's product is then picked by its residue index and shifted left by its recorded count. Elements equal to zero skip this path and give a zero product.

The controller is a state machine with these states and transitions:

- IDLE goes to ALIGN when `start` is high.
- ALIGN goes to SORT.
- SORT runs N cycles of odd-even compare-exchange, then goes to DEDUP.
- DEDUP spends N cycles, one per sorted entry, then goes to SCALE.
- SCALE starts the shift-add unit on one distinct step and goes to WAIT.
- WAIT holds until the unit is idle, then goes to ACCUM.
- ACCUM adds the result into the running sum. It returns to SCALE while distinct steps remain, and otherwise goes to LOOKUP.
- LOOKUP writes all products and goes to DONE.
- DONE raises `done` for one cycle and returns to IDLE.

Top module: `svp_engine`

## Requirements
- R1: After reset, `done` is 0 and every product lane of `prod_out` is 0.
- R2: When `done` is high, each lane i of `prod_out` (bits i*32 +: 32) equals vec_in element i (bits i*16 +: 16) times `scalar_in`, both taken as unsigned from the cycle `start` was accepted.
- R3: An element equal to zero yields a zero product, including an all-zero vector.
- R4: Vectors with repeated values, including a vector whose elements are all equal, yield correct products for every element.
- R5: Elements with trailing zero bits (powers of two up to 0x8000) and the largest operands (0xFFFF times 0xFFFF = 0xFFFE0001) yield exact 32-bit products with no overflow.
- R6: `done` is high for exactly one cycle per accepted `start`, and the engine is idle in the cycle after.
- R7: `start` and the load inputs are ignored while a computation is in progress; the products reflect only the values captured at acceptance.
- R8: After `done`, `prod_out` holds its values while no new `start` is given, whatever `vec_in` and `scalar_in` do.
- R9: A zero scalar yields all-zero products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation; sampled only while idle |
| vec_in | input | N*W (128) | Vector elements, element i at bits i*W +: W |
| scalar_in | input | W (16) | Unsigned scalar |
| done | output | 1 | One-cycle pulse when all products are valid |
| prod_out | output | N*PW (256) | Products, lane i at bits i*PW +: PW |

## Verification
Random vectors with random scalars give broad coverage of the sort and prefix path against a reference product. All-equal vectors and vectors with repeats exercise the merge of duplicates, where a wrong residue index shows up as a swapped product. All-zero and mixed-zero vectors separate the zero bypass from the residue path. Power-of-two and full-scale vectors expose errors in the trailing-zero count and in the shift-back and width handling. A zero scalar, a `start` pulsed mid-run with different data, and inputs changed after completion check that results depend only on the captured operands and stay held.

// File: rtl/svp_pkg.sv
package svp_pkg;

    // Controller states of the scalar-vector product engine
    typedef enum logic [3:0] {
        S_IDLE,
        S_ALIGN,
        S_SORT,
        S_DEDUP,
        S_SCALE,
        S_WAIT,
        S_ACCUM,
        S_LOOKUP,
        S_DONE
    } svp_state_e;

endpackage

// File: rtl/svp_tz_align.sv
// Strips trailing zero bits from one element and reports the count.
module svp_tz_align #(
    parameter int W   = 16,
    parameter int TZW = $clog2(W)
) (
    input  logic [W-1:0]   val,
    output logic [W-1:0]   residue,
    output logic [TZW-1:0] tz,
    output logic           is_zero
);
    logic found;

    always_comb begin
        is_zero = (val == '0);
        tz      = '0;
        found   = 1'b0;
        for (int b = 0; b < W; b++) begin
            if (!found && val[b]) begin
                tz    = TZW'(b);
                found = 1'b1;
            end
        end
        residue = val >> tz;
    end
endmodule

// File: rtl/svp_sort_step.sv
// One odd-even transposition phase over keys with attached indices.
module svp_sort_step #(
    parameter int N  = 8,
    parameter int W  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic                  odd_phase,
    input  logic [N-1:0][W-1:0]   key_in,
    input  logic [N-1:0][IW-1:0]  idx_in,
    output logic [N-1:0][W-1:0]   key_out,
    output logic [N-1:0][IW-1:0]  idx_out
);
    logic [N-1:0] swap;

    always_comb begin
        swap = '0;
        for (int k = 0; k < N - 1; k++) begin
            swap[k] = ((k % 2) == int'(odd_phase)) && (key_in[k] > key_in[k+1]);
        end
        for (int k = 0; k < N; k++) begin
            key_out[k] = key_in[k];
            idx_out[k] = idx_in[k];
            if (k < N - 1) begin
                if (swap[k]) begin
                    key_out[k] = key_in[k+1];
                    idx_out[k] = idx_in[k+1];
                end
            end
            if (k != 0) begin
                if (swap[k-1]) begin
                    key_out[k] = key_in[k-1];
                    idx_out[k] = idx_in[k-1];
                end
            end
        end
    end
endmodule

// File: rtl/svp_shadd_mul.sv
// Iterative shift-and-add scaler; finishes as soon as the multiplier runs out of set bits.
module svp_shadd_mul #(
    parameter int W  = 16,
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [W-1:0]  mcand_in,
    input  logic [W-1:0]  mplier_in,
    output logic          busy,
    output logic [PW-1:0] result
);
    logic [PW-1:0] mc_q;
    logic [W-1:0]  mp_q;
    logic [PW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_q  <= '0;
            mp_q  <= '0;
            acc_q <= '0;
        end else if (go) begin
            mc_q  <= PW'(mcand_in);
            mp_q  <= mplier_in;
            acc_q <= '0;
        end else if (mp_q != '0) begin
            if (mp_q[0]) begin
                acc_q <= acc_q + mc_q;
            end
            mc_q <= mc_q << 1;
            mp_q <= mp_q >> 1;
        end
    end

    assign busy   = (mp_q != '0);
    assign result = acc_q;
endmodule

// File: rtl/svp_engine.sv
module svp_engine
    import svp_pkg::*;
#(
    parameter int N  = 8,
    parameter int W  = 16,
    parameter int PW = 2 * W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [N*W-1:0]  vec_in,
    input  logic [W-1:0]    scalar_in,
    output logic            done,
    output logic [N*PW-1:0] prod_out
);
    localparam int IW  = (N > 1) ? $clog2(N) : 1;
    localparam int CW  = $clog2(N + 1);
    localparam int TZW = $clog2(W);

    svp_state_e state_q, state_d;

    logic [N-1:0][W-1:0]   vec_q;
    logic [W-1:0]          scal_q;
    logic [N-1:0][W-1:0]   res_w;
    logic [N-1:0][TZW-1:0] tz_w;
    logic [N-1:0]          zero_w;
    logic [N-1:0][TZW-1:0] tz_q;
    logic [N-1:0]          zero_q;
    logic [N-1:0][W-1:0]   key_q, key_nx;
    logic [N-1:0][IW-1:0]  idx_q, idx_nx;
    logic [CW-1:0]         step_q;
    logic [CW-1:0]         ucnt_q;
    logic [W-1:0]          last_q;
    logic [N-1:0][W-1:0]   diff_q;
    logic [N-1:0][IW-1:0]  map_q;
    logic [CW-1:0]         j_q;
    logic [PW-1:0]         run_q;
    logic [N-1:0][PW-1:0]  scaled_q;
    logic [N-1:0][PW-1:0]  prod_q;
    logic                  mul_go;
    logic                  mul_busy;
    logic [PW-1:0]         mul_res;
    logic [W-1:0]          cur_key;
    logic                  is_new;

    // Per-element alignment
    for (genvar g = 0; g < N; g++) begin : g_align
        svp_tz_align #(.W(W), .TZW(TZW)) u_align (
            .val     (vec_q[g]),
            .residue (res_w[g]),
            .tz      (tz_w[g]),
            .is_zero (zero_w[g])
        );
    end

    svp_sort_step #(.N(N), .W(W), .IW(IW)) u_sort (
        .odd_phase (step_q[0]),
        .key_in    (key_q),
        .idx_in    (idx_q),
        .key_out   (key_nx),
        .idx_out   (idx_nx)
    );

    svp_shadd_mul #(.W(W), .PW(PW)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (mul_go),
        .mcand_in  (scal_q),
        .mplier_in (diff_q[IW'(j_q)]),
        .busy      (mul_busy),
        .result    (mul_res)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and controller outputs
    always_comb begin
        state_d = state_q;
        done    = 1'b0;
        mul_go  = 1'b0;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_ALIGN;
            S_ALIGN:  state_d = S_SORT;
            S_SORT:   if (step_q == CW'(N - 1)) state_d = S_DEDUP;
            S_DEDUP:  if (step_q == CW'(N - 1)) state_d = S_SCALE;
            S_SCALE: begin
                mul_go  = 1'b1;
                state_d = S_WAIT;
            end
            S_WAIT:   if (!mul_busy) state_d = S_ACCUM;
            S_ACCUM: begin
                if (j_q + 1'b1 == ucnt_q) state_d = S_LOOKUP;
                else                      state_d = S_SCALE;
            end
            S_LOOKUP: state_d = S_DONE;
            S_DONE: begin
                done    = 1'b1;
                state_d = S_IDLE;
            end
            default:  state_d = S_IDLE;
        endcase
    end

    assign cur_key = key_q[IW'(step_q)];
    assign is_new  = (step_q == '0) || (cur_key != last_q);

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q    <= '0;
            scal_q   <= '0;
            tz_q     <= '0;
            zero_q   <= '0;
            key_q    <= '0;
            idx_q    <= '0;
            step_q   <= '0;
            ucnt_q   <= '0;
            last_q   <= '0;
            diff_q   <= '0;
            map_q    <= '0;
            j_q      <= '0;
            run_q    <= '0;
            scaled_q <= '0;
            prod_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        vec_q  <= vec_in;
                        scal_q <= scalar_in;
                    end
                end
                S_ALIGN: begin
                    for (int i = 0; i < N; i++) begin
                        key_q[i] <= res_w[i];
                        idx_q[i] <= IW'(i);
                    end
                    tz_q   <= tz_w;
                    zero_q <= zero_w;
                    step_q <= '0;
                    ucnt_q <= '0;
                    last_q <= '0;
                end
                S_SORT: begin
                    key_q  <= key_nx;
                    idx_q  <= idx_nx;
                    step_q <= (step_q == CW'(N - 1)) ? '0 : step_q + 1'b1;
                end
                S_DEDUP: begin
                    if (is_new) begin
                        diff_q[IW'(ucnt_q)]       <= cur_key - last_q;
                        last_q                    <= cur_key;
                        map_q[idx_q[IW'(step_q)]] <= IW'(ucnt_q);
                        ucnt_q                    <= ucnt_q + 1'b1;
                    end else begin
                        map_q[idx_q[IW'(step_q)]] <= IW'(ucnt_q - 1'b1);
                    end
                    step_q <= step_q + 1'b1;
                    j_q    <= '0;
                    run_q  <= '0;
                end
                S_SCALE, S_WAIT: begin
                end
                S_ACCUM: begin
                    run_q              <= run_q + mul_res;
                    scaled_q[IW'(j_q)] <= run_q + mul_res;
                    j_q                <= j_q + 1'b1;
                end
                S_LOOKUP: begin
                    for (int i = 0; i < N; i++) begin
                        prod_q[i] <= zero_q[i] ? '0 : (scaled_q[map_q[i]] << tz_q[i]);
                    end
                end
                S_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    assign prod_out = prod_q;
endmodule

// File: rtl/svp_engine_chk.sv
module svp_engine_chk #(
    parameter int N  = 8,
    parameter int W  = 16,
    parameter int PW = 2 * W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            idle,
    input logic            done,
    input logic [N*W-1:0]  vec_in,
    input logic [W-1:0]    scalar_in,
    input logic [N*PW-1:0] prod_out
);
    logic [N*W-1:0] cap_v;
    logic [W-1:0]   cap_s;
    logic           ref_bad;
    logic           zero_bad;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_v <= '0;
            cap_s <= '0;
        end else if (idle && start) begin
            cap_v <= vec_in;
            cap_s <= scalar_in;
        end
    end

    always_comb begin
        ref_bad  = 1'b0;
        zero_bad = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (prod_out[i*PW +: PW] != PW'(cap_v[i*W +: W]) * PW'(cap_s)) ref_bad = 1'b1;
            if (cap_v[i*W +: W] == '0 && prod_out[i*PW +: PW] != '0) zero_bad = 1'b1;
        end
    end

    // R2 and R7: products match the operands captured at acceptance
    prod_ref_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !ref_bad);

    // R3
    zero_elem_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !zero_bad);

    // R9
    zero_scalar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_s == '0) |-> (prod_out == '0));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> idle);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !start) |=> $stable(prod_out));
endmodule

bind svp_engine svp_engine_chk #(.N(N), .W(W), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .idle      (state_q == svp_pkg::S_IDLE),
    .done      (done),
    .vec_in    (vec_in),
    .scalar_in (scalar_in),
    .prod_out  (prod_out)
);

// File: tb/sim_svp_engine.sv
`timescale 1ns/1ps
module sim_svp_engine;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int PW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [N*W-1:0]  vec_in = '0;
    logic [W-1:0]    scalar_in = '0;
    logic            done;
    logic [N*PW-1:0] prod_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    svp_engine #(.N(N), .W(W), .PW(PW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .vec_in    (vec_in),
        .scalar_in (scalar_in),
        .done      (done),
        .prod_out  (prod_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Runs one computation and checks every lane; disturb pulses start mid-run with other data.
    task automatic run_vec(input logic [N*W-1:0] v, input logic [W-1:0] s,
                           input string req, input bit disturb);
        int t;
        logic [PW-1:0] exp;
        @(negedge clk);
        vec_in = v;
        scalar_in = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 2000) begin
            if (disturb && t == 4) begin
                start = 1'b1;
                vec_in = ~v;
                scalar_in = ~s;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            t++;
        end
        start = 1'b0;
        check(done, req, "done reached", 64'(done), 64'd1);
        for (int i = 0; i < N; i++) begin
            exp = PW'(v[i*W +: W]) * PW'(s);
            check(prod_out[i*PW +: PW] == exp, req, $sformatf("lane %0d", i),
                  64'(prod_out[i*PW +: PW]), 64'(exp));
        end
        @(negedge clk);
        check(!done, "R6", "done one cycle", 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", "done in reset", 64'(done), 64'd0);
        check(prod_out == '0, "R1", "prod in reset", 64'(prod_out[63:0]), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);
        check(prod_out == '0, "R1", "prod after reset", 64'(prod_out[63:0]), 64'd0);
    endtask

    task automatic t_random();
        logic [N*W-1:0] v;
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
            run_vec(v, W'($urandom), "R2", 1'b0);
        end
    endtask

    task automatic t_all_equal();
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = 16'h0123;
        run_vec(v, 16'h7A5C, "R4", 1'b0);
        for (int i = 0; i < N; i++) v[i*W +: W] = 16'h0600;
        run_vec(v, 16'hFFFF, "R4", 1'b0);
        // repeats with differing shifts: 3, 6, 12 share residue 3
        for (int i = 0; i < N; i++) v[i*W +: W] = (i % 3 == 0) ? 16'd3 : (i % 3 == 1) ? 16'd6 : 16'd12;
        run_vec(v, 16'h1234, "R4", 1'b0);
    endtask

    task automatic t_zero();
        logic [N*W-1:0] v;
        run_vec('0, 16'hBEEF, "R3", 1'b0);
        for (int i = 0; i < N; i++) v[i*W +: W] = (i % 2 == 0) ? 16'd0 : W'(16'h0F0F + i);
        run_vec(v, 16'hABCD, "R3", 1'b0);
    endtask

    task automatic t_pow2();
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(1) << (2 * i);
        run_vec(v, 16'hFFFF, "R5", 1'b0);
        for (int i = 0; i < N; i++) v[i*W +: W] = 16'h8000 >> i;
        run_vec(v, 16'hC001, "R5", 1'b0);
        for (int i = 0; i < N; i++) v[i*W +: W] = 16'hFFFF;
        run_vec(v, 16'hFFFF, "R5", 1'b0);
    endtask

    task automatic t_scalar_zero();
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom) | 16'h1;
        run_vec(v, 16'h0000, "R9", 1'b0);
    endtask

    task automatic t_start_busy();
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(16'h0101 * (i + 1));
        run_vec(v, 16'h0035, "R7", 1'b1);
    endtask

    task automatic t_hold();
        logic [N*W-1:0] v;
        logic [N*PW-1:0] snap;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(16'h1111 + 16'h0203 * i);
        run_vec(v, 16'h00FD, "R8", 1'b0);
        snap = prod_out;
        vec_in = ~v;
        scalar_in = 16'h5555;
        repeat (30) @(negedge clk);
        for (int i = 0; i < N; i++) begin
            check(prod_out[i*PW +: PW] == snap[i*PW +: PW], "R8", $sformatf("hold lane %0d", i),
                  64'(prod_out[i*PW +: PW]), 64'(snap[i*PW +: PW]));
        end
        check(done == 1'b0, "R8", "no done while idle", 64'(done), 64'd0);
    endtask

    initial begin
        t_reset();
        t_random();
        t_all_equal();
        t_zero();
        t_pow2();
        t_scalar_zero();
        t_start_busy();
        t_hold();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule